// File: doc/BRIEF.md
# Dual-Channel Companded PCM Serial Transmitter

This block sends two 8-bit companded voice characters per frame as serial bit streams, most significant bit first, one bit per rising edge of the bit clock. A rising edge on the frame strobe, sampled on the bit clock, starts a frame. The first bit appears after that same clock edge. Each output behaves like an open-drain pin. A drive-enable is asserted only while the pin pulls low inside its own slot, and the pin floats at every other time.

In parallel mode, each channel has its own pin for an 8-bit slot. In serial mode, the first pin carries channel 1 and then channel 2 over 16 bit times, and the second pin stays released. When A-law is selected, the block inverts the alternate bits of each character on the way out. When mu-law is selected, the character goes out unchanged. A power-down input releases both pins at once and abandons any frame in progress.

Top module: `pcm_duo_tx`

## Requirements
- R1: Out of reset, both drive-enables are 0 and both data outputs are 1.
- R2: A frame starts at the first clock edge that samples `fsync` high after a low sample. The first bit is visible after that edge. Holding `fsync` high does not start another frame.
- R3: In parallel mode, each pin sends its character most significant bit first, one bit per clock edge, for 8 bit times. After that the pin is released until the next frame.
- R4: While `pwr_down` is 1, both drive-enables are 0 and both data outputs are 1 in the same cycle. A frame in progress is abandoned, and no frame starts.
- R5: In parallel mode, channel 1 goes on `dout_a` and channel 2 goes on `dout_b`.
- R6: In serial mode, `dout_a` sends the 8 channel 1 bits and then the 8 channel 2 bits, 16 bit times in all. `dout_b_oe` stays 0 and `dout_b` stays 1.
- R7: With `alaw_sel` = 1, each character is XORed with 0x55 (bit positions 6, 4, 2 and 0 are inverted, bit 7 being the first bit sent). With `alaw_sel` = 0, the character is sent unchanged.
- R8: In A-law mode, the characters 0xFF, 0x80, 0x00 and 0x7F are sent as 10101010, 11010101, 01010101 and 00101010. These are positive full scale, +0, -0 and negative full scale.
- R9: A drive-enable is 1 only while its pin is inside its slot and the bit is 0. A data output is 1 whenever its pin is outside its slot.
- R10: The channel words, the mode and the law are captured at frame start. Changing them during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; bits launch on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame strobe, sampled on `clk` |
| ch_a_word | input | 8 | Channel 1 character |
| ch_b_word | input | 8 | Channel 2 character |
| serial_mode | input | 1 | 1: both channels on `dout_a`; 0: one pin per channel |
| alaw_sel | input | 1 | 1: A-law alternate-bit inversion; 0: mu-law |
| pwr_down | input | 1 | Releases both pins and stops framing |
| dout_a | output | 1 | Pin 1 data bit (1 when released) |
| dout_a_oe | output | 1 | Pin 1 pull-low enable |
| dout_b | output | 1 | Pin 2 data bit (1 when released) |
| dout_b_oe | output | 1 | Pin 2 pull-low enable |

## Verification
The assertions assume that `fsync`, `pwr_down` and the channel, mode and law inputs are synchronous to the bit clock. They also assume these inputs do not change close to its rising edge. The bench meets this by changing every input on the falling edge only. It reads outputs on the falling edge as well, so the rising-edge launch and the frame-start edge are never ambiguous. After mode and law are captured, the checks on slot length and on the unused second pin depend only on those captured values. The bench therefore flips the live mode and law inputs in mid-frame to exercise exactly that case.

// File: rtl/pcm_duo_pkg.sv
package pcm_duo_pkg;

  localparam int unsigned PCM_W = 8;

  typedef enum logic {
    LAW_MU = 1'b0,
    LAW_A  = 1'b1
  } law_e;

  // Alternate-bit mask: every bit at an even position from the LSB.
  function automatic logic [PCM_W-1:0] alt_mask();
    logic [PCM_W-1:0] m;
    for (int i = 0; i < PCM_W; i++) m[i] = ((i % 2) == 0);
    return m;
  endfunction

endpackage

// File: rtl/pcm_law_map.sv
module pcm_law_map
  import pcm_duo_pkg::*;
#(
  parameter int unsigned W = PCM_W
) (
  input  logic [W-1:0] char_in,
  input  law_e         law,
  output logic [W-1:0] char_out
);

  localparam logic [W-1:0] MASK = W'(alt_mask());

  always_comb begin
    if (law == LAW_A) char_out = char_in ^ MASK;
    else              char_out = char_in;
  end

endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl #(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic pwr_down,
  input  logic serial_mode,
  output logic load,
  output logic shift,
  output logic active,
  output logic serial_q
);

  localparam int unsigned CNT_W = $clog2(2 * W);
  localparam logic [CNT_W-1:0] LAST_PAR = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] LAST_SER = CNT_W'(2 * W - 1);

  logic             fs_q, fs_d;
  logic             act_q, act_d;
  logic             ser_q, ser_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             start;

  assign start = fsync & ~fs_q & ~pwr_down;
  assign last  = ser_q ? LAST_SER : LAST_PAR;

  always_comb begin
    fs_d  = fsync;
    act_d = act_q;
    ser_d = ser_q;
    cnt_d = cnt_q;
    if (start) begin
      act_d = 1'b1;
      ser_d = serial_mode;
      cnt_d = '0;
    end else if (act_q) begin
      if (pwr_down || cnt_q == last) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b0;
      act_q <= 1'b0;
      ser_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      fs_q  <= fs_d;
      act_q <= act_d;
      ser_q <= ser_d;
      cnt_q <= cnt_d;
    end
  end

  assign load     = start;
  assign shift    = act_q & ~start;
  assign active   = act_q;
  assign serial_q = ser_q;

  // R2: a detected strobe opens a slot at bit index zero
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act_q && cnt_q == '0));
  // R3: the bit counter never runs past the slot length
  p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= last));
  // R4: power-down ends any frame on the next edge
  p_pd_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !act_q);

endmodule

// File: rtl/pcm_shift_pair.sv
module pcm_shift_pair #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic         msb_a,
  output logic         msb_b
);

  logic [W-1:0] sa_q, sa_d;
  logic [W-1:0] sb_q, sb_d;

  // Register a is fed from register b, so in serial mode channel 2
  // follows channel 1 on pin a without any extra multiplexing.
  always_comb begin
    sa_d = sa_q;
    sb_d = sb_q;
    if (load) begin
      sa_d = word_a;
      sb_d = word_b;
    end else if (shift) begin
      sa_d = {sa_q[W-2:0], sb_q[W-1]};
      sb_d = {sb_q[W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= '1;
      sb_q <= '1;
    end else begin
      sa_q <= sa_d;
      sb_q <= sb_d;
    end
  end

  assign msb_a = sa_q[W-1];
  assign msb_b = sb_q[W-1];

  // R3: a loaded character presents its MSB on the next cycle
  p_load_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb_a == $past(word_a[W-1])));

endmodule

// File: rtl/pcm_duo_tx.sv
module pcm_duo_tx
  import pcm_duo_pkg::*;
#(
  parameter int unsigned WORD_W = PCM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [WORD_W-1:0] ch_a_word,
  input  logic [WORD_W-1:0] ch_b_word,
  input  logic              serial_mode,
  input  logic              alaw_sel,
  input  logic              pwr_down,
  output logic              dout_a,
  output logic              dout_a_oe,
  output logic              dout_b,
  output logic              dout_b_oe
);

  localparam int unsigned NCH = 2;

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WORD_W-1:0] raw_w [NCH];
  logic [WORD_W-1:0] enc_w [NCH];
  law_e              law;

  assign raw_w[0] = ch_a_word;
  assign raw_w[1] = ch_b_word;
  assign law      = law_e'(alaw_sel);

  for (genvar g = 0; g < NCH; g++) begin : g_law
    pcm_law_map #(.W(WORD_W)) u_map (
      .char_in (raw_w[g]),
      .law     (law),
      .char_out(enc_w[g])
    );
  end

  logic load, shift, active, serial_q;

  pcm_frame_ctl #(.W(WORD_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .fsync      (fsync),
    .pwr_down   (pwr_down),
    .serial_mode(serial_mode),
    .load       (load),
    .shift      (shift),
    .active     (active),
    .serial_q   (serial_q)
  );

  logic msb_a, msb_b;

  pcm_shift_pair #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (load),
    .shift (shift),
    .word_a(enc_w[0]),
    .word_b(enc_w[1]),
    .msb_a (msb_a),
    .msb_b (msb_b)
  );

  logic slot_a, slot_b;

  assign slot_a    = active & ~pwr_down;
  assign slot_b    = active & ~serial_q & ~pwr_down;
  assign dout_a    = slot_a ? msb_a : 1'b1;
  assign dout_b    = slot_b ? msb_b : 1'b1;
  assign dout_a_oe = slot_a & ~msb_a;
  assign dout_b_oe = slot_b & ~msb_b;

  // R4: power-down releases both pins
  p_pd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    pwr_down |-> (!dout_a_oe && !dout_b_oe));
  // R6: in serial mode pin b is never pulled
  p_serial_b_idle_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    serial_q |-> !dout_b_oe);
  // R9: a pin is pulled only while it carries a zero
  p_od_zero_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dout_a_oe |-> !dout_a) and (dout_b_oe |-> !dout_b));
  // R9: outside a frame both pins float
  p_idle_float_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !active |-> (dout_a && dout_b && !dout_a_oe && !dout_b_oe));

endmodule

// File: tb/pcm_duo_tx_tb_top.sv
module pcm_duo_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fsync;
  logic [7:0] ch_a_word, ch_b_word;
  logic       serial_mode, alaw_sel, pwr_down;
  logic       dout_a, dout_a_oe, dout_b, dout_b_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcm_duo_tx dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .ch_a_word(ch_a_word), .ch_b_word(ch_b_word),
    .serial_mode(serial_mode), .alaw_sel(alaw_sel), .pwr_down(pwr_down),
    .dout_a(dout_a), .dout_a_oe(dout_a_oe),
    .dout_b(dout_b), .dout_b_oe(dout_b_oe)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic       ser;
    logic       law;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 8'h3C, 1'b0, 1'b0},
    '{8'h80, 8'h7F, 1'b0, 1'b0},
    '{8'h0F, 8'hF0, 1'b0, 1'b1},
    '{8'h5A, 8'hC3, 1'b1, 1'b0},
    '{8'h12, 8'hFE, 1'b1, 1'b1},
    '{8'hFF, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [15:0] cap_a, cap_b;
  int          od_bad, b_drv;
  logic        released;

  // Runs one frame; flips every live input after bit 1 (R10).
  task automatic do_frame(input logic [7:0] a, input logic [7:0] b, input logic ser, input logic law);
    int len;
    len = ser ? 16 : 8;
    cap_a = '1; cap_b = '1; od_bad = 0; b_drv = 0;
    @(negedge clk);
    ch_a_word = a; ch_b_word = b; serial_mode = ser; alaw_sel = law; fsync = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      cap_a[15-k] = dout_a;
      cap_b[15-k] = dout_b;
      if (dout_a_oe != !dout_a) od_bad++;
      if (!ser && dout_b_oe != !dout_b) od_bad++;
      if (ser && (dout_b_oe || !dout_b)) b_drv++;
      if (k == 0) fsync = 1'b0;
      if (k == 1) begin
        ch_a_word = ~a; ch_b_word = ~b; serial_mode = ~ser; alaw_sel = ~law;
      end
    end
    @(negedge clk);
    released = dout_a && dout_b && !dout_a_oe && !dout_b_oe;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ea, eb;
    rst_n = 1'b0; fsync = 1'b0; ch_a_word = '0; ch_b_word = '0;
    serial_mode = 1'b0; alaw_sel = 1'b0; pwr_down = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dout_a && dout_b && !dout_a_oe && !dout_b_oe, "R1 reset",
        {12'h0, dout_a, dout_a_oe, dout_b, dout_b_oe}, 16'h000A);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_a && dout_b && !dout_a_oe && !dout_b_oe, "R1 idle after reset",
        {12'h0, dout_a, dout_a_oe, dout_b, dout_b_oe}, 16'h000A);

    // Vector walk: R2 R3 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      do_frame(VECS[v].a, VECS[v].b, VECS[v].ser, VECS[v].law);
      ea = VECS[v].law ? (VECS[v].a ^ 8'h55) : VECS[v].a;
      eb = VECS[v].law ? (VECS[v].b ^ 8'h55) : VECS[v].b;
      if (!VECS[v].ser) begin
        chk(cap_a[15:8] == ea, "R3 R5 R7 R10 pin a", {8'h0, cap_a[15:8]}, {8'h0, ea});
        chk(cap_b[15:8] == eb, "R5 R7 R10 pin b", {8'h0, cap_b[15:8]}, {8'h0, eb});
      end else begin
        chk(cap_a == {ea, eb}, "R6 R7 R10 serial pin a", cap_a, {ea, eb});
        chk(b_drv == 0, "R6 pin b idle", 16'(b_drv), 16'h0);
      end
      chk(od_bad == 0, "R9 open-drain", 16'(od_bad), 16'h0);
      chk(released, "R3 R9 release after slot", {15'h0, released}, 16'h1);
    end

    // R8: A-law signed zero and full-scale codes
    do_frame(8'hFF, 8'h80, 1'b0, 1'b1);
    chk(cap_a[15:8] == 8'b10101010, "R8 +full", {8'h0, cap_a[15:8]}, 16'h00AA);
    chk(cap_b[15:8] == 8'b11010101, "R8 +0", {8'h0, cap_b[15:8]}, 16'h00D5);
    do_frame(8'h00, 8'h7F, 1'b0, 1'b1);
    chk(cap_a[15:8] == 8'b01010101, "R8 -0", {8'h0, cap_a[15:8]}, 16'h0055);
    chk(cap_b[15:8] == 8'b00101010, "R8 -full", {8'h0, cap_b[15:8]}, 16'h002A);

    // R2: strobe held high starts a single frame only
    @(negedge clk);
    ch_a_word = 8'h00; ch_b_word = 8'h00; serial_mode = 1'b0; alaw_sel = 1'b0; fsync = 1'b1;
    @(negedge clk);
    chk(dout_a_oe && dout_b_oe, "R2 first bit after start edge",
        {14'h0, dout_a_oe, dout_b_oe}, 16'h3);
    repeat (12) @(negedge clk);
    chk(!dout_a_oe && !dout_b_oe && dout_a, "R2 no restart on held strobe",
        {14'h0, dout_a_oe, dout_b_oe}, 16'h0);
    fsync = 1'b0;
    @(negedge clk);

    // R4: power-down mid-frame releases and aborts
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    @(negedge clk);
    pwr_down = 1'b1;
    #1;
    chk(!dout_a_oe && !dout_b_oe && dout_a && dout_b, "R4 immediate release",
        {12'h0, dout_a, dout_a_oe, dout_b, dout_b_oe}, 16'h000A);
    @(negedge clk);
    pwr_down = 1'b0;
    @(negedge clk);
    chk(!dout_a_oe && !dout_b_oe, "R4 frame abandoned",
        {14'h0, dout_a_oe, dout_b_oe}, 16'h0);

    // R4: strobe during power-down starts nothing
    pwr_down = 1'b1;
    fsync = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0;
    @(negedge clk);
    chk(!dout_a_oe && !dout_b_oe, "R4 no start while powered down",
        {14'h0, dout_a_oe, dout_b_oe}, 16'h0);
    fsync = 1'b0;
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule